// File: doc/BRIEF.md
# Store Byte-Lane Mask Decoder

This block sits beside a processor's memory stage and turns one memory access into byte write enables for three memories: an instruction store, a data store and an interrupt-handler store. It looks at the top nibble of the effective address to decide which memories a store reaches. It looks at the low address bits and the access size to decide which byte lanes are written. Lanes are numbered big-endian, so byte offset 0 is the most significant lane.

One region is mirrored. A store there writes the instruction store and the data store in the same cycle with the same mask, which lets code be patched while it is also visible as data. Loads never write. A halfword or word store that is not aligned to its natural boundary writes nothing and raises an error flag instead. The store data itself is not shifted here. All outputs are registered and appear one cycle after the request.

Top module: `lane_mask_unit`

## Requirements
- R1: A request with kind 2'b00 (load) produces all-zero masks on all three memories and no error, one cycle later.
- R2: A store whose address bits [31:28] equal 4'h1 writes only the data-store mask; the instruction and handler masks stay 4'b0000.
- R3: A store whose address bits [31:28] equal 4'h3 writes the instruction-store and data-store masks with identical values; the handler mask stays 4'b0000.
- R4: A store whose address bits [31:28] equal 4'h4 writes only the handler-store mask.
- R5: A store to any other top nibble writes no mask and raises no error.
- R6: A byte store (kind 2'b11) at address offset k (bits [1:0]) sets only mask bit 3-k. So offset 3 gives 4'b0001 and offset 0 gives 4'b1000.
- R7: A halfword store (kind 2'b10) gives 4'b1100 at offset 0 and 4'b0011 at offset 2.
- R8: A word store (kind 2'b01) at offset 0 gives 4'b1111.
- R9: A halfword store at an odd offset, or a word store at a nonzero offset, sets align_err for one cycle and leaves all three masks at 4'b0000. Byte stores never set align_err.
- R10: Outputs reflect the request sampled at the previous rising edge. A cycle with req_valid low yields zero masks and no error on the next cycle.
- R11: While rst_n is low and directly after reset, all masks and align_err are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Effective byte address |
| req_kind | input | 2 | 00 load, 01 word store, 10 halfword store, 11 byte store |
| imem_we | output | 4 | Instruction-store byte write mask, bit 3 = offset 0 |
| dmem_we | output | 4 | Data-store byte write mask |
| isr_we | output | 4 | Handler-store byte write mask |
| align_err | output | 1 | Misaligned store flagged, masks suppressed |

## Verification
Every access kind is applied at every one of the four byte offsets in each of six address regions: the three live regions and three dead ones. The byte stores show whether the lane order is big-endian rather than little-endian. The odd halfword and nonzero word offsets separate the alignment check from lane selection. Repeating the same pattern in the dead regions shows that the error flag does not depend on the region while the masks do. Idle cycles placed between requests show that the registers clear when no strobe is present rather than holding the last mask.

// File: rtl/lmu_pkg.sv
package lmu_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD = 2'b00,
      ACC_WORD = 2'b01,
      ACC_HALF = 2'b10,
      ACC_BYTE = 2'b11
   } acc_kind_e;

   typedef struct packed {
      logic imem;
      logic dmem;
      logic isr;
   } mem_sel_t;
endpackage

// File: rtl/lmu_lane_decode.sv
module lmu_lane_decode
   import lmu_pkg::*;
#(
   parameter int LANES = 4,
   localparam int OFS_W = $clog2(LANES)
) (
   input  acc_kind_e          kind,
   input  logic [OFS_W-1:0]   ofs,
   output logic [LANES-1:0]   lanes,
   output logic               misaligned
);
   generate
      if (LANES < 4 || (1 << OFS_W) != LANES) begin : g_bad_lanes
         $error("lmu_lane_decode: LANES must be a power of two, at least 4");
      end
   endgenerate

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      // big-endian: lane bit i carries byte number LANES-1-i
      localparam int BYTE_NUM = LANES - 1 - i;
      localparam logic [OFS_W-1:0] BN = BYTE_NUM[OFS_W-1:0];
      assign lanes[i] = (kind == ACC_BYTE) ? (ofs == BN) :
                        (kind == ACC_HALF) ? (ofs[OFS_W-1:1] == BN[OFS_W-1:1]) :
                        (kind == ACC_WORD);
   end

   always_comb begin
      unique case (kind)
         ACC_HALF: misaligned = ofs[0];
         ACC_WORD: misaligned = |ofs;
         default:  misaligned = 1'b0;
      endcase
   end
endmodule

// File: rtl/lmu_region_decode.sv
module lmu_region_decode
   import lmu_pkg::*;
#(
   parameter int          REGION_W   = 4,
   parameter logic [3:0]  RGN_DATA   = 4'h1,
   parameter logic [3:0]  RGN_SHARED = 4'h3,
   parameter logic [3:0]  RGN_ISR    = 4'h4,
   parameter bit          MIRROR_EN  = 1'b1
) (
   input  logic [REGION_W-1:0] region,
   output mem_sel_t            sel
);
   generate
      if (REGION_W != 4) begin : g_bad_region
         $error("lmu_region_decode: region codes are 4 bits wide");
      end
   endgenerate

   logic hit_data, hit_shared, hit_isr;
   assign hit_data   = (region == RGN_DATA);
   assign hit_shared = (region == RGN_SHARED);
   assign hit_isr    = (region == RGN_ISR);

   generate
      if (MIRROR_EN) begin : g_mirror
         assign sel.imem = hit_shared;
         assign sel.dmem = hit_data | hit_shared;
      end else begin : g_split
         assign sel.imem = hit_shared;
         assign sel.dmem = hit_data;
      end
   endgenerate
   assign sel.isr = hit_isr;
endmodule

// File: rtl/lmu_mask_reg.sv
module lmu_mask_reg #(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] imem_d,
   input  logic [LANES-1:0] dmem_d,
   input  logic [LANES-1:0] isr_d,
   input  logic             err_d,
   output logic [LANES-1:0] imem_q,
   output logic [LANES-1:0] dmem_q,
   output logic [LANES-1:0] isr_q,
   output logic             err_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imem_q <= '0;
         dmem_q <= '0;
         isr_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         imem_q <= imem_d;
         dmem_q <= dmem_d;
         isr_q  <= isr_d;
         err_q  <= err_d;
      end
   end
endmodule

// File: rtl/lane_mask_unit.sv
module lane_mask_unit
   import lmu_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int LANES    = 4,
   parameter int REGION_W = 4,
   localparam int OFS_W   = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_kind,
   output logic [LANES-1:0]  imem_we,
   output logic [LANES-1:0]  dmem_we,
   output logic [LANES-1:0]  isr_we,
   output logic              align_err
);
   generate
      if (REGION_W + OFS_W > ADDR_W) begin : g_bad_addr
         $error("lane_mask_unit: address too narrow for region and offset");
      end
   endgenerate

   acc_kind_e        kind;
   logic [LANES-1:0] lanes;
   logic             misaligned;
   mem_sel_t         sel;
   logic             is_store, write_ok;
   logic [LANES-1:0] imem_d, dmem_d, isr_d;
   logic             err_d;

   assign kind = acc_kind_e'(req_kind);

   lmu_lane_decode #(.LANES(LANES)) u_lanes (
      .kind       (kind),
      .ofs        (req_addr[OFS_W-1:0]),
      .lanes      (lanes),
      .misaligned (misaligned)
   );

   lmu_region_decode #(.REGION_W(REGION_W)) u_region (
      .region (req_addr[ADDR_W-1 -: REGION_W]),
      .sel    (sel)
   );

   assign is_store = req_valid && (kind != ACC_LOAD);
   assign write_ok = is_store && !misaligned;
   assign err_d    = is_store && misaligned;
   assign imem_d   = (write_ok && sel.imem) ? lanes : '0;
   assign dmem_d   = (write_ok && sel.dmem) ? lanes : '0;
   assign isr_d    = (write_ok && sel.isr)  ? lanes : '0;

   lmu_mask_reg #(.LANES(LANES)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .imem_d (imem_d),
      .dmem_d (dmem_d),
      .isr_d  (isr_d),
      .err_d  (err_d),
      .imem_q (imem_we),
      .dmem_q (dmem_we),
      .isr_q  (isr_we),
      .err_q  (align_err)
   );
endmodule

// File: rtl/lmu_checker.sv
module lmu_checker #(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_kind,
   input logic [LANES-1:0]  imem_we,
   input logic [LANES-1:0]  dmem_we,
   input logic [LANES-1:0]  isr_we,
   input logic              align_err
);
   // R1
   load_writes_nothing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'b00) |=>
      (imem_we == '0 && dmem_we == '0 && isr_we == '0 && !align_err));

   // R2
   data_region_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[ADDR_W-1 -: 4] == 4'h1) |=>
      (imem_we == '0 && isr_we == '0));

   // R3
   shared_region_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[ADDR_W-1 -: 4] == 4'h3) |=>
      (imem_we == dmem_we && isr_we == '0));

   // R4
   isr_region_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[ADDR_W-1 -: 4] == 4'h4) |=>
      (imem_we == '0 && dmem_we == '0));

   // R9
   error_blocks_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      align_err |-> (imem_we == '0 && dmem_we == '0 && isr_we == '0));

   // R9
   byte_never_misaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'b11) |=> !align_err);

   // R10
   idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (imem_we == '0 && dmem_we == '0 && isr_we == '0 && !align_err));

   // R6
   byte_single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'b11 && req_addr[ADDR_W-1 -: 4] == 4'h1) |=>
      ($countones(dmem_we) == 1));
endmodule

bind lane_mask_unit lmu_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_lmu_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .req_kind  (req_kind),
   .imem_we   (imem_we),
   .dmem_we   (dmem_we),
   .isr_we    (isr_we),
   .align_err (align_err)
);

// File: tb/lane_mask_unit_bench.sv
module lane_mask_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_kind = '0;
   logic [3:0]  imem_we, dmem_we, isr_we;
   logic        align_err;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [12:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   lane_mask_unit u_lane_mask_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_kind(req_kind), .imem_we(imem_we), .dmem_we(dmem_we),
      .isr_we(isr_we), .align_err(align_err)
   );

   // expected {imem, dmem, isr, err} from the requirements
   function automatic logic [12:0] model(input logic v, input logic [31:0] a,
                                         input logic [1:0] k);
      logic [3:0] m;
      logic       err;
      logic [3:0] im, dm, is;
      m = 4'b0000; err = 1'b0; im = '0; dm = '0; is = '0;
      if (v && k != 2'b00) begin
         case (k)
            2'b11: m = 4'b1000 >> a[1:0];                         // R6
            2'b10: begin
               if (a[0]) err = 1'b1;                              // R9
               else m = (a[1] ? 4'b0011 : 4'b1100);               // R7
            end
            default: begin
               if (a[1:0] != 2'b00) err = 1'b1;                   // R9
               else m = 4'b1111;                                  // R8
            end
         endcase
         if (!err) begin
            case (a[31:28])
               4'h1: dm = m;                                      // R2
               4'h3: begin im = m; dm = m; end                    // R3
               4'h4: is = m;                                      // R4
               default: ;                                         // R5
            endcase
         end
      end
      return {im, dm, is, err};
   endfunction

   function automatic string label(input logic v, input logic [31:0] a,
                                   input logic [1:0] k);
      if (!v) return "R10";
      if (k == 2'b00) return "R1";
      if ((k == 2'b10 && a[0]) || (k == 2'b01 && a[1:0] != 0)) return "R9";
      case (a[31:28])
         4'h1: return (k == 2'b11) ? "R2/R6" : (k == 2'b10) ? "R2/R7" : "R2/R8";
         4'h3: return "R3";
         4'h4: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic drive(input logic v, input logic [31:0] a, input logic [1:0] k);
      @(negedge clk);
      req_valid = v;
      req_addr  = a;
      req_kind  = k;
      exp_q.push_back(model(v, a, k));
      tag_q.push_back(label(v, a, k));
   endtask

   // monitor: compare just after the edge that registered each request
   always @(posedge clk) begin
      #1;
      if (rst_n && exp_q.size() > 0) begin
         logic [12:0] e;
         string       t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_vec++;
         if ({imem_we, dmem_we, isr_we, align_err} !== e) begin
            n_bad++;
            $display("FAIL %s: got imem=%b dmem=%b isr=%b err=%b, want imem=%b dmem=%b isr=%b err=%b",
                     t, imem_we, dmem_we, isr_we, align_err,
                     e[12:9], e[8:5], e[4:1], e[0]);
         end
      end
   end

   initial begin
      logic [3:0] regions [6];
      regions = '{4'h1, 4'h3, 4'h4, 4'h0, 4'h2, 4'hF};
      // R11: during and directly after reset
      repeat (3) @(negedge clk);
      n_vec++;
      if ({imem_we, dmem_we, isr_we, align_err} !== 13'b0) begin
         n_bad++;
         $display("FAIL R11: got %b, want 0", {imem_we, dmem_we, isr_we, align_err});
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_vec++;
      if ({imem_we, dmem_we, isr_we, align_err} !== 13'b0) begin
         n_bad++;
         $display("FAIL R11: got %b after reset, want 0", {imem_we, dmem_we, isr_we, align_err});
      end
      for (int r = 0; r < 6; r++) begin
         for (int k = 0; k < 4; k++) begin
            for (int o = 0; o < 4; o++) begin
               drive(1'b1, {regions[r], 24'h00_0120, 2'b00, o[1:0]}, k[1:0]);
               if (o == 3) drive(1'b0, {regions[r], 28'h000_0000}, 2'b11); // R10
            end
         end
      end
      // R10: invalid strobe with a store pattern still writes nothing
      drive(1'b0, 32'h1000_0003, 2'b01);
      drive(1'b1, 32'h3000_0042, 2'b10);
      drive(1'b1, 32'h1000_0063, 2'b11);
      drive(1'b0, 32'h1000_0063, 2'b11);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout, want completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule